// File: doc/BRIEF.md
# Counter Bank Control and Readback Port

Byte-wide register front end for a bank of three counter channels. A 2-bit address picks one of three channel data ports (0 to 2) or the control port (3). Writes to the control port either set up a channel (byte access pattern, counting mode, decimal flag), freeze a channel's running count into a one-shot latch, or issue a multi-channel read-back command that can freeze counts and/or status of any subset of channels in one write.

Data-port writes are assembled into 16-bit reload values according to the channel's byte access pattern and handed to the channel with a single-cycle load strobe. Data-port reads return, in order of priority, a pending status byte, a pending frozen count, or the live count taken from the channel, one byte per read. The counting logic lives in the channels; this block only observes their live count and output level and hands them reload values and their mode settings.

Top module: `tmr_regif`

## Requirements
- R1: After reset every channel has access pattern 3 (low then high byte), counting mode 3, decimal flag 0, no pending latch, and both byte sequencers at the low byte; `ch_mode_o` reads 3 for each channel and `load_o` is 0.
- R2: A write to address 3 with bits 7:6 = n (0..2) and bits 5:4 non-zero sets channel n's access pattern to bits 5:4, counting mode to bits 3:1 and decimal flag to bit 0 (visible on `ch_mode_o`/`ch_bcd_o` the next cycle); it drops any pending count or status latch of channel n and returns both byte sequencers to the low byte. Control writes never pulse `load_o`.
- R3: Access pattern 1 (low byte only): a data write pulses `load_o[n]` in the same cycle with value {8'h00, byte}. Access pattern 2 (high byte only): value {byte, 8'h00}.
- R4: Access pattern 3: the first data write only stores the byte (no load); the second pulses `load_o[n]` with {second, first}; the next write is again taken as a low byte.
- R5: A control write with bits 7:6 = n and bits 5:4 = 0 freezes `cnt_i` of channel n (as sampled at that clock edge) if channel n has no unread frozen count; otherwise it has no effect.
- R6: A control write with bits 7:6 = 3 is a read-back: bits 1, 2, 3 select channels 0, 1, 2; for each selected channel bit 5 = 0 freezes the count and bit 4 = 0 freezes the status, each only when that latch is not already pending.
- R7: The frozen status byte is {output level, 1'b0, access pattern[1:0], counting mode[2:0], decimal flag}, bit 7 first.
- R8: A data read returns a pending status byte first (and clears it); otherwise a pending frozen count: pattern 1 gives the low byte and clears, pattern 2 the high byte and clears, pattern 3 the low byte then the high byte, then clears.
- R9: With nothing pending, reads give the live count: low byte for pattern 1, high byte for pattern 2, and for pattern 3 alternately low then high, starting low.
- R10: `rdata_o` is 0 while `rd_i` is low; a read of address 3 returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Port select: 0..2 channel data, 3 control |
| wr_i | input | 1 | Write strobe, one byte per cycle |
| rd_i | input | 1 | Read strobe, one byte per cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle `rd_i` is high |
| cnt_i | input | 48 | Live 16-bit count of each channel, channel 0 in the low bits |
| out_i | input | 3 | Output level of each channel |
| load_o | output | 3 | Reload strobe per channel |
| load_val_o | output | 48 | 16-bit reload value per channel |
| ch_mode_o | output | 9 | 3-bit counting mode per channel |
| ch_bcd_o | output | 3 | Decimal flag per channel |

## Verification
`load_o` and `load_val_o` answer a data write combinationally in the same cycle, and `rdata_o` answers a read in the same cycle; mode outputs, latches and sequencer steps take effect at the edge that ends the access, so they show on the following access. The bench drives each access on the falling edge, samples the combinational answers 1 ns later, and only then updates its own model, so every later access is compared against state as of the preceding edge. Counts and output levels fed to the block are held steady across each access, so the value captured by a latch command is the one the bench had applied during that cycle.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;

  // pending frozen-count state; values line up with acc_e on capture
  typedef enum logic [1:0] {
    LAT_NONE = 2'd0,
    LAT_LO   = 2'd1,
    LAT_HI   = 2'd2,
    LAT_BOTH = 2'd3
  } lat_e;
endpackage

// File: rtl/tmr_ctrl_dec.sv
module tmr_ctrl_dec
  import tmr_regif_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [NUM_CH-1:0] cfg_wr_o,
  output logic [NUM_CH-1:0] cnt_lat_o,
  output logic [NUM_CH-1:0] sts_lat_o,
  output logic [NUM_CH-1:0] dwr_o,
  output logic [NUM_CH-1:0] drd_o
);
  logic ctl_wr, rb_cmd;
  assign ctl_wr = wr_i && (addr_i == 2'd3);
  assign rb_cmd = ctl_wr && (wdata_i[7:6] == 2'd3);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit          = ctl_wr && (wdata_i[7:6] == 2'(c));
    assign cfg_wr_o[c]  = hit && (wdata_i[5:4] != ACC_LATCH);
    assign cnt_lat_o[c] = (hit && (wdata_i[5:4] == ACC_LATCH)) ||
                          (rb_cmd && wdata_i[c+1] && !wdata_i[5]);
    assign sts_lat_o[c] = rb_cmd && wdata_i[c+1] && !wdata_i[4];
    assign dwr_o[c]     = wr_i && (addr_i == 2'(c));
    assign drd_o[c]     = rd_i && !wr_i && (addr_i == 2'(c));
  end
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
  import tmr_regif_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic              cnt_lat_i,
  input  logic              sts_lat_i,
  input  logic              dwr_i,
  input  logic              drd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              out_i,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [BYTE_W-1:0] rd_byte_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              bcd_o
);
  acc_e              acc_q;
  lat_e              lat_q;
  logic              wr_hi_q, rd_hi_q, sts_pend_q;
  logic [BYTE_W-1:0] wlat_q, sts_q;
  logic [CNT_W-1:0]  lat_val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q      <= ACC_WORD;
      mode_o     <= MODE_W'(3);
      bcd_o      <= 1'b0;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      wlat_q     <= '0;
      lat_q      <= LAT_NONE;
      lat_val_q  <= '0;
      sts_pend_q <= 1'b0;
      sts_q      <= '0;
    end else begin
      if (cfg_wr_i) begin
        acc_q      <= acc_e'(wdata_i[5:4]);
        mode_o     <= wdata_i[3:1];
        bcd_o      <= wdata_i[0];
        wr_hi_q    <= 1'b0;
        rd_hi_q    <= 1'b0;
        lat_q      <= LAT_NONE;
        sts_pend_q <= 1'b0;
      end
      if (cnt_lat_i && lat_q == LAT_NONE) begin
        lat_val_q <= cnt_i;
        lat_q     <= lat_e'(acc_q);
      end
      if (sts_lat_i && !sts_pend_q) begin
        sts_q      <= {out_i, 1'b0, acc_q, mode_o, bcd_o};
        sts_pend_q <= 1'b1;
      end
      if (dwr_i && acc_q == ACC_WORD) begin
        if (!wr_hi_q) wlat_q <= wdata_i;
        wr_hi_q <= !wr_hi_q;
      end
      if (drd_i) begin
        if (sts_pend_q)              sts_pend_q <= 1'b0;
        else if (lat_q != LAT_NONE)  lat_q <= (lat_q == LAT_BOTH) ? LAT_HI : LAT_NONE;
        else if (acc_q == ACC_WORD)  rd_hi_q <= !rd_hi_q;
      end
    end
  end

  assign load_o = dwr_i && (acc_q != ACC_WORD || wr_hi_q);

  always_comb begin
    unique case (acc_q)
      ACC_LO:  load_val_o = {{BYTE_W{1'b0}}, wdata_i};
      ACC_HI:  load_val_o = {wdata_i, {BYTE_W{1'b0}}};
      default: load_val_o = {wdata_i, wlat_q};
    endcase
  end

  logic live_hi;
  assign live_hi = (acc_q == ACC_HI) || (acc_q == ACC_WORD && rd_hi_q);

  always_comb begin
    if (sts_pend_q)          rd_byte_o = sts_q;
    else if (lat_q != LAT_NONE)
      rd_byte_o = (lat_q == LAT_HI) ? lat_val_q[CNT_W-1:BYTE_W] : lat_val_q[BYTE_W-1:0];
    else
      rd_byte_o = live_hi ? cnt_i[CNT_W-1:BYTE_W] : cnt_i[BYTE_W-1:0];
  end
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
  import tmr_regif_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               addr_i,
  input  logic                     wr_i,
  input  logic                     rd_i,
  input  logic [7:0]               wdata_i,
  output logic [7:0]               rdata_o,
  input  logic [NUM_CH*16-1:0]     cnt_i,
  input  logic [NUM_CH-1:0]        out_i,
  output logic [NUM_CH-1:0]        load_o,
  output logic [NUM_CH*16-1:0]     load_val_o,
  output logic [NUM_CH*3-1:0]      ch_mode_o,
  output logic [NUM_CH-1:0]        ch_bcd_o
);
  logic [NUM_CH-1:0] cfg_wr, cnt_lat, sts_lat, dwr, drd;
  logic [NUM_CH-1:0][BYTE_W-1:0] rd_byte;

  tmr_ctrl_dec #(.NUM_CH(NUM_CH)) u_dec (
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .wdata_i  (wdata_i),
    .cfg_wr_o (cfg_wr),
    .cnt_lat_o(cnt_lat),
    .sts_lat_o(sts_lat),
    .dwr_o    (dwr),
    .drd_o    (drd)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tmr_chan_port u_port (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cfg_wr_i  (cfg_wr[c]),
      .cnt_lat_i (cnt_lat[c]),
      .sts_lat_i (sts_lat[c]),
      .dwr_i     (dwr[c]),
      .drd_i     (drd[c]),
      .wdata_i   (wdata_i),
      .cnt_i     (cnt_i[c*CNT_W +: CNT_W]),
      .out_i     (out_i[c]),
      .load_o    (load_o[c]),
      .load_val_o(load_val_o[c*CNT_W +: CNT_W]),
      .rd_byte_o (rd_byte[c]),
      .mode_o    (ch_mode_o[c*MODE_W +: MODE_W]),
      .bcd_o     (ch_bcd_o[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (rd_i && addr_i == 2'(c)) rdata_o = rd_byte[c];
  end
endmodule

// File: rtl/tmr_regif_chk.sv
module tmr_regif_chk #(
  parameter int NUM_CH = 3
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [1:0]          addr_i,
  input logic                wr_i,
  input logic                rd_i,
  input logic [7:0]          wdata_i,
  input logic [7:0]          rdata_o,
  input logic [NUM_CH-1:0]   load_o,
  input logic [NUM_CH*3-1:0] ch_mode_o,
  input logic [NUM_CH-1:0]   ch_bcd_o
);
  p_cfg_apply_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == 2'd3 && wdata_i[7:6] == 2'd0 && wdata_i[5:4] != 2'd0
    |=> ch_mode_o[2:0] == $past(wdata_i[3:1]) && ch_bcd_o[0] == $past(wdata_i[0]));

  p_ctl_no_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == 2'd3 |-> load_o == '0);

  p_load_source_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o != '0 |-> wr_i && addr_i != 2'd3 && $countones(load_o) == 1 && load_o[addr_i]);

  p_word_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && addr_i == 2'd3 && wdata_i[7:4] == 4'b0011
    |=> !(wr_i && addr_i == 2'd0) || !load_o[0]);

  p_rd_ctl_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && addr_i == 2'd3 |-> rdata_o == 8'h00);

  p_rd_idle_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == 8'h00);
endmodule

bind tmr_regif tmr_regif_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .load_o   (load_o),
  .ch_mode_o(ch_mode_o),
  .ch_bcd_o (ch_bcd_o)
);

// File: tb/tmr_regif_test.sv
module tmr_regif_test;
  logic clk_i = 1'b0;
  always #2 clk_i = ~clk_i;

  logic        rst_ni;
  logic [1:0]  addr_i;
  logic        wr_i, rd_i;
  logic [7:0]  wdata_i, rdata_o;
  logic [47:0] cnt_i, load_val_o;
  logic [2:0]  out_i, load_o, ch_bcd_o;
  logic [8:0]  ch_mode_o;

  logic [15:0] live [3];
  logic        outl [3];
  assign cnt_i = {live[2], live[1], live[0]};
  assign out_i = {outl[2], outl[1], outl[0]};

  tmr_regif uut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // bench model of each channel, from the requirements
  int          m_acc [3], m_mode [3], m_bcd [3], m_whi [3], m_rhi [3], m_lst [3], m_sp [3];
  logic [7:0]  m_wlat [3], m_sts [3];
  logic [15:0] m_lval [3];
  string       m_src [3];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic m_reset();
    for (int c = 0; c < 3; c++) begin
      m_acc[c] = 3; m_mode[c] = 3; m_bcd[c] = 0; m_whi[c] = 0; m_rhi[c] = 0;
      m_lst[c] = 0; m_sp[c] = 0; m_wlat[c] = 0; m_sts[c] = 0; m_lval[c] = 0; m_src[c] = "R5";
    end
  endtask

  task automatic m_cnt_latch(int c, string src);
    if (m_lst[c] == 0) begin
      m_lval[c] = live[c]; m_lst[c] = m_acc[c]; m_src[c] = src;
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    logic [2:0]  emask;
    logic [15:0] eval;
    string       tag;
    int          c;
    @(negedge clk_i);
    check("R10", {24'h0, rdata_o}, 32'h0);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    #1;
    emask = '0; eval = '0; tag = "R3";
    if (a != 2'd3) begin
      c = int'(a);
      case (m_acc[c])
        1: begin emask[c] = 1'b1; eval = {8'h00, d}; end
        2: begin emask[c] = 1'b1; eval = {d, 8'h00}; end
        default: begin
          tag = "R4";
          if (m_whi[c] != 0) begin emask[c] = 1'b1; eval = {d, m_wlat[c]}; m_whi[c] = 0; end
          else begin m_wlat[c] = d; m_whi[c] = 1; end
        end
      endcase
      check(tag, {29'h0, load_o}, {29'h0, emask});
      if (emask != 0) check(tag, {16'h0, load_val_o[c*16 +: 16]}, {16'h0, eval});
    end else begin
      check("R2", {29'h0, load_o}, 32'h0);
      c = int'(d[7:6]);
      if (c != 3) begin
        if (d[5:4] == 2'd0) m_cnt_latch(c, "R5");
        else begin
          m_acc[c] = int'(d[5:4]); m_mode[c] = int'(d[3:1]); m_bcd[c] = int'(d[0]);
          m_whi[c] = 0; m_rhi[c] = 0; m_lst[c] = 0; m_sp[c] = 0;
        end
      end else begin
        for (int k = 0; k < 3; k++) if (d[k+1]) begin
          if (!d[5]) m_cnt_latch(k, "R6");
          if (!d[4] && m_sp[k] == 0) begin
            m_sts[k] = {outl[k], 1'b0, 2'(m_acc[k]), 3'(m_mode[k]), 1'(m_bcd[k])};
            m_sp[k] = 1;
          end
        end
      end
    end
    @(posedge clk_i); #1 wr_i = 1'b0;
    if (a == 2'd3 && d[7:6] != 2'd3 && d[5:4] != 2'd0) begin
      c = int'(d[7:6]);
      check("R2", {29'h0, ch_mode_o[c*3 +: 3]}, {29'h0, d[3:1]});
      check("R2", {31'h0, ch_bcd_o[c]}, {31'h0, d[0]});
    end
  endtask

  task automatic bus_rd(input logic [1:0] a);
    logic [7:0] e;
    string      tag;
    int         c;
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #1;
    if (a == 2'd3) begin e = 8'h00; tag = "R10"; end
    else begin
      c = int'(a);
      if (m_sp[c] != 0) begin e = m_sts[c]; tag = "R7 R8"; m_sp[c] = 0; end
      else if (m_lst[c] != 0) begin
        e = (m_lst[c] == 2) ? m_lval[c][15:8] : m_lval[c][7:0];
        tag = {m_src[c], " R8"};
        m_lst[c] = (m_lst[c] == 3) ? 2 : 0;
      end else begin
        e = (m_acc[c] == 2 || (m_acc[c] == 3 && m_rhi[c] != 0)) ? live[c][15:8] : live[c][7:0];
        tag = "R9";
        if (m_acc[c] == 3) m_rhi[c] = 1 - m_rhi[c];
      end
    end
    check(tag, {24'h0, rdata_o}, {24'h0, e});
    @(posedge clk_i); #1 rd_i = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL all: watchdog act=timeout exp=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    rst_ni = 1'b0; addr_i = '0; wr_i = 1'b0; rd_i = 1'b0; wdata_i = '0;
    for (int c = 0; c < 3; c++) begin live[c] = 16'h1234 + 16'(c * 16'h1111); outl[c] = c[0]; end
    m_reset();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    #1;
    // R1 reset state
    check("R1", {23'h0, ch_mode_o}, {23'h0, 9'b011_011_011});
    check("R1", {29'h0, ch_bcd_o}, 32'h0);
    check("R1", {29'h0, load_o}, 32'h0);
    check("R1", {24'h0, rdata_o}, 32'h0);
    for (int c = 0; c < 3; c++) repeat (3) bus_rd(2'(c));
    bus_wr(2'(0), 8'hA5);
    bus_wr(2'(0), 8'h5A);

    // configuration and data-write sweep
    for (int c = 0; c < 3; c++)
      for (int acc = 1; acc < 4; acc++)
        for (int md = 0; md < 8; md++)
          for (int b = 0; b < 2; b++) begin
            bus_wr(2'd3, {2'(c), 2'(acc), 3'(md), 1'(b)});
            for (int k = 0; k < 3; k++)
              bus_wr(2'(c), 8'(c * 61 + acc * 29 + md * 7 + b * 3 + k * 17));
            live[c] = 16'(c * 4099 + acc * 771 + md * 97 + b * 13);
            repeat (3) bus_rd(2'(c));
            bus_rd(2'd3);
          end

    // every control byte, with repeat latch while pending
    for (int v = 0; v < 256; v++) begin
      for (int c = 0; c < 3; c++) begin live[c] = 16'(v * 613 + c * 4099); outl[c] = v[c]; end
      bus_wr(2'd3, 8'(v));
      for (int c = 0; c < 3; c++) begin live[c] = live[c] ^ 16'hF0F0; outl[c] = ~outl[c]; end
      bus_wr(2'd3, 8'(v));
      for (int c = 0; c < 3; c++) repeat (3) bus_rd(2'(c));
      bus_rd(2'd3);
      for (int c = 0; c < 3; c++) begin live[c] = live[c] + 16'h0101; bus_rd(2'(c)); end
    end

    // pseudo-random mix
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (lf[2:0])
        3'd0, 3'd1: bus_wr(2'd3, lf[15:8]);
        3'd2, 3'd3: bus_wr(lf[4:3], lf[12:5]);
        3'd4, 3'd5, 3'd6: bus_rd(lf[4:3]);
        default: begin
          live[int'(lf[9:8]) % 3] = {lf[7:0], lf[15:8]};
          outl[int'(lf[11:10]) % 3] = lf[12];
        end
      endcase
    end

    done = 1;
    summary();
    $finish;
  end
endmodule